// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual address into a physical address by reading a four-level translation tree from memory, one directory per level. A translate request carries the virtual address and the frame number of the top directory, which plays the part of the per-process root register. The walker then issues one 8-byte read per level through a simple memory read port. Each read is indexed by a 9-bit slice of the virtual address. Pages are 4096 bytes, and each directory is one page of 512 entries.

Bit 0 of every entry is its present flag. Bits 51:12 hold the frame number of the next directory, or, at the last level, the frame of the data page. A missing entry at any level ends the walk with a fault that reports the level. A present leaf yields its frame concatenated with the 12-bit page offset, together with the leaf's permission bits 11:1. The walker handles one translation at a time. Each result is shown as a single-cycle response pulse.

Top module: `ptw_walker`

## Requirements
- R1: While `rst_n` is low, and after it is released, the walker is idle: `req_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0. A reset applied during a walk abandons that walk, and the next request is served normally.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle after the response pulse. While `req_ready` is 1, `mem_req_valid` and `rsp_valid` are 0.
- R3: The first read goes to `root_ppn`×4096 + `req_vaddr[47:39]`×8, in the cycle after acceptance. The later reads use `req_vaddr[38:30]`, `[29:21]` and `[20:12]` in that order, each against the base (bits 51:12 of the previous entry)×4096. Read addresses are always 8-byte aligned.
- R4: Each level issues exactly one read, with `mem_req_valid` high for one cycle. The walker moves on only when `mem_rsp_valid` arrives after that read. A `mem_rsp_valid` with no read outstanding is ignored.
- R5: An entry whose bit 0 is 0 ends the walk. The response then has `rsp_fault`=1 and `rsp_level` set to 3, 2, 1 or 0 for the top, second, third or leaf level, and no further read is issued.
- R6: When the leaf is present, the response has `rsp_fault`=0, `rsp_level`=0, `rsp_paddr`={leaf[51:12], vaddr[11:0]} and `rsp_perm`=leaf[11:1].
- R7: Bits 63:48 of `req_vaddr` and bits 63:52 of every entry have no effect on read addresses or on the response.
- R8: `rsp_valid` is high for exactly one cycle per accepted request. `req_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translate request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address; bits 47:0 used |
| root_ppn | input | 40 | Frame number of the top directory, sampled on acceptance |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Walk ended on an absent entry |
| rsp_level | output | 2 | Level of the final entry (3 top .. 0 leaf) |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_perm | output | 11 | Permission bits of the leaf entry |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` for each read request, at least one cycle after the request. They also assume that `req_valid` is raised only after reset has been released. The bench memory model obeys both rules. It answers each observed read once, after a latency of one to three cycles. Its only extra responses are deliberate stray pulses, sent while no read is outstanding. A reset during a walk is applied between a request and its answer, and the bench never answers the abandoned read afterwards.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VIN_W  = 64;
  localparam int VA_W   = 48;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 9;
  localparam int LEVELS = 4;
  localparam int PA_W   = 52;
  localparam int PTE_W  = 64;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PERM_W = OFF_W - 1;
  localparam int LVL_W  = $clog2(LEVELS);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_L4    = 3'd1,
    ST_L3    = 3'd2,
    ST_L2    = 3'd3,
    ST_L1    = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W   = ptw_pkg::VA_W,
  parameter int OFF_W  = ptw_pkg::OFF_W,
  parameter int IDX_W  = ptw_pkg::IDX_W,
  parameter int LEVELS = ptw_pkg::LEVELS,
  parameter int PA_W   = ptw_pkg::PA_W,
  parameter int PTE_W  = ptw_pkg::PTE_W,
  localparam int PPN_W = PA_W - OFF_W,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int ENT_SH = $clog2(PTE_W / 8)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] base_ppn,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx_tab [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_tab[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
  end

  assign addr = {base_ppn, {OFF_W{1'b0}}} + (PA_W'(idx_tab[level]) << ENT_SH);
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int OFF_W = ptw_pkg::OFF_W,
  parameter int PA_W  = ptw_pkg::PA_W,
  parameter int PTE_W = ptw_pkg::PTE_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int PERM_W = OFF_W - 1
) (
  input  logic [PTE_W-1:0]  entry,
  input  logic [OFF_W-1:0]  offset,
  output logic              present,
  output logic [PPN_W-1:0]  next_ppn,
  output logic [PA_W-1:0]   leaf_paddr,
  output logic [PERM_W-1:0] leaf_perm
);
  assign present    = entry[0];
  assign next_ppn   = entry[PA_W-1:OFF_W];
  assign leaf_perm  = entry[OFF_W-1:1];
  assign leaf_paddr = {entry[PA_W-1:OFF_W], offset};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W   = ptw_pkg::VA_W,
  parameter int OFF_W  = ptw_pkg::OFF_W,
  parameter int PA_W   = ptw_pkg::PA_W,
  parameter int LEVELS = ptw_pkg::LEVELS,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int PERM_W = OFF_W - 1,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              req_ready,
  output logic              mem_req_valid,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic [PPN_W-1:0]  base_ppn,
  output logic [VA_W-1:0]   vaddr_q,
  input  logic              mem_rsp_valid,
  input  logic              ent_present,
  input  logic [PPN_W-1:0]  ent_ppn,
  input  logic [PA_W-1:0]   leaf_paddr,
  input  logic [PERM_W-1:0] leaf_perm,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [LVL_W-1:0]  rsp_level,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm
);
  walk_state_e      state_q, state_d;
  logic             issued_q, issued_d;
  logic             base_en, vaddr_en, rsp_en;
  logic [PPN_W-1:0] base_d;
  logic             in_walk;

  assign in_walk = (state_q == ST_L4) || (state_q == ST_L3) ||
                   (state_q == ST_L2) || (state_q == ST_L1);

  always_comb begin
    unique case (state_q)
      ST_L4:   cur_lvl = LVL_W'(3);
      ST_L3:   cur_lvl = LVL_W'(2);
      ST_L2:   cur_lvl = LVL_W'(1);
      default: cur_lvl = LVL_W'(0);
    endcase
  end

  always_comb begin
    state_d  = state_q;
    issued_d = issued_q;
    base_d   = base_q;
    base_en  = 1'b0;
    vaddr_en = 1'b0;
    rsp_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_L4;
          issued_d = 1'b0;
          base_d   = root_ppn;
          base_en  = 1'b1;
          vaddr_en = 1'b1;
        end
      end
      ST_L4, ST_L3, ST_L2, ST_L1: begin
        if (!issued_q) begin
          issued_d = 1'b1;
        end else if (mem_rsp_valid) begin
          issued_d = 1'b0;
          if (!ent_present) begin
            state_d = ST_FAULT;
            rsp_en  = 1'b1;
          end else if (state_q == ST_L1) begin
            state_d = ST_DONE;
            rsp_en  = 1'b1;
          end else begin
            state_d = walk_state_e'(state_q + 3'd1);
            base_d  = ent_ppn;
            base_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  logic [PPN_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk) begin
    if (base_en)  base_q  <= base_d;
    if (vaddr_en) vaddr_q <= req_vaddr;
    if (rsp_en) begin
      rsp_fault <= !ent_present;
      rsp_level <= cur_lvl;
      rsp_paddr <= leaf_paddr;
      rsp_perm  <= leaf_perm;
    end
  end

  assign base_ppn      = base_q;
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = in_walk && !issued_q;
  assign rsp_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid)); // R2
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req_valid); // R3
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R4
  AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_level == '0)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R8
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VIN_W-1:0]    req_vaddr,
  input  logic [PPN_W-1:0]    root_ppn,
  output logic                mem_req_valid,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [LVL_W-1:0]    rsp_level,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [PERM_W-1:0]   rsp_perm
);
  logic [LVL_W-1:0]  cur_lvl;
  logic [PPN_W-1:0]  base_ppn;
  logic [VA_W-1:0]   vaddr_q;
  logic              ent_present;
  logic [PPN_W-1:0]  ent_ppn;
  logic [PA_W-1:0]   leaf_paddr;
  logic [PERM_W-1:0] leaf_perm;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr[VA_W-1:0]),
    .root_ppn      (root_ppn),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .cur_lvl       (cur_lvl),
    .base_ppn      (base_ppn),
    .vaddr_q       (vaddr_q),
    .mem_rsp_valid (mem_rsp_valid),
    .ent_present   (ent_present),
    .ent_ppn       (ent_ppn),
    .leaf_paddr    (leaf_paddr),
    .leaf_perm     (leaf_perm),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level),
    .rsp_paddr     (rsp_paddr),
    .rsp_perm      (rsp_perm)
  );

  ptw_addr_gen u_addr (
    .vaddr    (vaddr_q),
    .level    (cur_lvl),
    .base_ppn (base_ppn),
    .addr     (mem_req_addr)
  );

  ptw_entry_dec u_dec (
    .entry      (mem_rsp_data),
    .offset     (vaddr_q[OFF_W-1:0]),
    .present    (ent_present),
    .next_ppn   (ent_ppn),
    .leaf_paddr (leaf_paddr),
    .leaf_perm  (leaf_perm)
  );

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R3
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !mem_req_valid); // R5
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [39:0] root_ppn;
  logic        mem_req_valid;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [51:0] rsp_paddr;
  logic [10:0] rsp_perm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .root_ppn(root_ppn), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_entry(input int lv, input logic [63:0] va,
                                           input bit present);
    logic [39:0] ppn;
    logic [10:0] pm;
    ppn = 40'hC0_0000_0000 ^ (40'(lv) << 32) ^ {4'h0, va[47:12]};
    pm  = 11'(lv * 341) ^ va[10:0];
    return {12'hFA5, ppn, pm, present};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // fault_at: level (3..0) whose entry is absent; -1 for a full walk
  task automatic walk(input logic [63:0] va, input logic [39:0] root,
                      input int fault_at, input int lat);
    logic [39:0] base;
    logic [63:0] ent;
    logic [51:0] exp_addr;
    int          last;
    base = root;
    last = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; root_ppn = root;
    @(negedge clk);
    req_valid = 1'b0;
    root_ppn  = ~root;
    chk(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    for (int lv = 3; lv >= 0; lv--) begin
      for (int w = 0; w < 8 && !mem_req_valid; w++) @(negedge clk);
      exp_addr = {base, 12'h000} + (52'(va[12 + 9*lv +: 9]) << 3);
      chk(mem_req_valid == 1'b1, "R4 read issued", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == exp_addr, "R3 entry address", 64'(mem_req_addr),
          64'(exp_addr));
      @(negedge clk);
      for (int k = 0; k < lat; k++) begin
        chk(mem_req_valid == 1'b0, "R4 single read per level",
            64'(mem_req_valid), 64'd0);
        @(negedge clk);
      end
      ent = mk_entry(lv, va, lv != fault_at);
      mem_rsp_valid = 1'b1; mem_rsp_data = ent;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      last = lv;
      if (lv == fault_at) break;
      base = ent[51:12];
    end
    chk(rsp_valid == 1'b1, "R8 response pulse", 64'(rsp_valid), 64'd1);
    chk(mem_req_valid == 1'b0, "R5 no read after end", 64'(mem_req_valid), 64'd0);
    if (fault_at >= 0) begin
      chk(rsp_fault == 1'b1, "R5 fault flag", 64'(rsp_fault), 64'd1);
      chk(rsp_level == 2'(last), "R5 fault level", 64'(rsp_level), 64'(last));
    end else begin
      chk(rsp_fault == 1'b0, "R6 no fault", 64'(rsp_fault), 64'd0);
      chk(rsp_level == 2'd0, "R6 leaf level", 64'(rsp_level), 64'd0);
      chk(rsp_paddr == {ent[51:12], va[11:0]}, "R6 physical address",
          64'(rsp_paddr), 64'({ent[51:12], va[11:0]}));
      chk(rsp_perm == ent[11:1], "R6 permission bits", 64'(rsp_perm),
          64'(ent[11:1]));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 pulse ends", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R8 ready after response", 64'(req_ready), 64'd1);
  endtask

  initial begin
    int pick [4];
    int n;
    logic [63:0] va;
    pick[0] = 0; pick[1] = 1; pick[2] = 170; pick[3] = 511;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; root_ppn = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 no read in reset", 64'(mem_req_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // stray response while idle: R4
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && rsp_valid == 1'b0,
        "R4 stray response ignored", {61'd0, req_ready, mem_req_valid, rsp_valid},
        64'd4);

    // index sweep over all four levels
    n = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            va = {16'h0, 9'(pick[a]), 9'(pick[b]), 9'(pick[c]), 9'(pick[d]),
                  12'(n * 37)};
            walk(va, 40'h12_3456_7000 + 40'(n), -1, n % 3 + 1);
            n++;
          end

    // faults at every level
    for (int lv = 3; lv >= 0; lv--)
      for (int k = 0; k < 4; k++)
        walk({16'h0, 9'(pick[k]), 9'(pick[3-k]), 9'(k * 99), 9'(lv * 77),
              12'hABC}, 40'hF_0000_0000 + 40'(k), lv, k % 3 + 1);

    // R7: upper virtual bits ignored (entries already carry junk in 63:52)
    walk(64'hFFFF_0000_0000_0000 | 64'h0000_8040_2010_0FFF,
         40'h00_0000_0001, -1, 1);
    walk(64'hA5A5_7FFF_FFFF_F123, 40'h55_5555_5555, -1, 2);
    walk(64'h1234_7FFF_FFFF_F123, 40'h55_5555_5555, 1, 2);

    // R1: reset during a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h0000_1234_5678_9ABC; root_ppn = 40'h77;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && rsp_valid == 1'b0,
        "R1 walk abandoned", {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 idle after reset release", 64'(req_ready), 64'd1);
    walk(64'h0000_0102_0304_0506, 40'h99, -1, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule